// File: doc/BRIEF.md
# Radar Transmit Gate Controller

This block decides, cycle by cycle, whether a downstream chirp oscillator should be running. It drives one registered gate, `txActive`. A rising edge on that gate restarts the oscillator's phase. While the gate is high, the oscillator outputs a chirp. While it is low, the output is held at zero.

Three operating modes are supported:

- **Pulsed:** the gate opens for a programmable number of cycles at the start of every repetition interval, and is closed for the remainder of that interval.
- **Continuous tone:** the gate is held high permanently.
- **Repeating chirp:** the gate stays high except for a single-cycle dip at the end of every chirp period. The dip produces a fresh rising edge that restarts the sweep.

The chirp period counter is separate from the repetition-interval state machine. A burst length can stop pulsed operation after a fixed number of intervals.

Software or a sequencer sets the mode, the lengths and the burst count, then raises `enable`. Any of the following returns the gate low on the next clock and rearms every counter:

- dropping `enable`;
- changing `mode`.

Top module: `tx_gate_top`

## Requirements
- R1: While `rstN` is low, and on the first edge after it, `txActive` is 0.
- R2: In pulsed mode (`mode` = 0), with 1 <= `pulseWidth` <= `priLen`, the first steady cycle starts an interval. `txActive` is then 1 for `pulseWidth` cycles and 0 for `priLen - pulseWidth` cycles. This repeats with period `priLen`.
- R3: In pulsed mode, a nonzero `pulseCount` ends the run after that many intervals, and `txActive` then stays 0 until a restart. A zero `pulseCount` repeats without limit.
- R4: In continuous-tone mode (`mode` = 1), `txActive` is 1 on every edge on which the mode is steady.
- R5: In repeating-chirp mode (`mode` = 2), with `pulseWidth` >= 2, `txActive` is 1 for `pulseWidth - 1` cycles and then 0 for exactly one cycle, repeating with period `pulseWidth`.
- R6: In repeating-chirp mode the gate timing does not depend on `priLen`. Changing `priLen` on any cycle leaves the output sequence unchanged.
- R7: A cycle in which `enable` is 0 or `mode` differs from the previous cycle makes `txActive` 0 on the next edge. It also clears all counters, so the next steady cycle begins a fresh interval or period.
- R8: `mode` = 3 is an off setting: `txActive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request; low rearms the block |
| mode | input | 2 | 0 pulsed, 1 continuous tone, 2 repeating chirp, 3 off |
| pulseWidth | input | CNT_W | Pulse length (pulsed) or chirp period (repeating chirp), in cycles |
| priLen | input | CNT_W | Repetition interval in cycles (pulsed) |
| pulseCount | input | BURST_W | Number of intervals before stopping; 0 means endless |
| txActive | output | 1 | Registered gate to the oscillator |

## Verification
`txActive` is a register, so every result appears exactly one edge after the inputs that cause it. The bench drives inputs on the falling edge and advances its reference model by one step for the rising edge that follows. It compares the output on the next falling edge. A restart is therefore visible one edge after `enable` drops or `mode` changes, and the first high cycle of a run comes one edge after the first steady cycle. Whenever lengths or the burst count change, the bench first drops `enable` for one cycle. This keeps every segment starting from cleared counters, as the requirements assume.

// File: rtl/tx_gate_pkg.sv
package tx_gate_pkg;
  typedef enum logic [1:0] {
    MODE_PULSED = 2'd0,
    MODE_CW     = 2'd1,
    MODE_CHIRP  = 2'd2,
    MODE_OFF    = 2'd3
  } txMode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_REST = 2'd2,
    ST_DONE = 2'd3
  } gateState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic clrAll;
    logic priRun;
    logic chirpRun;
  } dpCmd_t;

  // datapath -> control flags
  typedef struct packed {
    logic widthHit;
    logic priHit;
    logic chirpHit;
    logic burstHit;
  } dpStat_t;
endpackage

// File: rtl/tx_gate_dp.sv
module tx_gate_dp
  import tx_gate_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             cmd,
  input  logic [CNT_W-1:0]   pulseWidth,
  input  logic [CNT_W-1:0]   priLen,
  input  logic [BURST_W-1:0] pulseCount,
  output dpStat_t            stat
);
  localparam int CW1 = CNT_W + 1;
  localparam int BW1 = BURST_W + 1;

  logic [CNT_W-1:0]   priCnt;
  logic [CNT_W-1:0]   chirpCnt;
  logic [BURST_W-1:0] pulseCnt;

  logic [CW1-1:0] priNext;
  logic [CW1-1:0] chirpNext;
  logic [BW1-1:0] pulseNext;

  always_comb begin
    priNext   = {1'b0, priCnt} + CW1'(1);
    chirpNext = {1'b0, chirpCnt} + CW1'(1);
    pulseNext = {1'b0, pulseCnt} + BW1'(1);
    stat.widthHit = (priNext == {1'b0, pulseWidth});
    stat.priHit   = (priNext >= {1'b0, priLen});
    stat.chirpHit = (chirpNext >= {1'b0, pulseWidth});
    stat.burstHit = (pulseCount != '0) && (pulseNext == {1'b0, pulseCount});
  end

  // interval counter and burst counter (pulsed timing)
  always_ff @(posedge clk) begin
    if (!rstN || cmd.clrAll) begin
      priCnt   <= '0;
      pulseCnt <= '0;
    end else if (cmd.priRun) begin
      if (stat.priHit) begin
        priCnt   <= '0;
        pulseCnt <= pulseCnt + BURST_W'(1);
      end else begin
        priCnt <= priCnt + CNT_W'(1);
      end
    end
  end

  // chirp period counter, independent of the interval timing
  always_ff @(posedge clk) begin
    if (!rstN || cmd.clrAll) begin
      chirpCnt <= '0;
    end else if (cmd.chirpRun) begin
      chirpCnt <= stat.chirpHit ? '0 : chirpCnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tx_gate_ctrl.sv
module tx_gate_ctrl
  import tx_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] mode,
  input  dpStat_t    stat,
  output dpCmd_t     cmd,
  output logic       txActive
);
  txMode_e    modeNow;
  txMode_e    modeQ;
  gateState_e state;
  gateState_e stateNext;
  logic       txNext;
  logic       restart;

  always_comb begin
    modeNow   = txMode_e'(mode);
    restart   = !enable || (modeNow != modeQ);
    stateNext = state;
    txNext    = 1'b0;
    cmd       = '0;
    if (restart) begin
      cmd.clrAll = 1'b1;
      stateNext  = ST_IDLE;
    end else begin
      unique case (modeNow)
        MODE_PULSED: begin
          cmd.priRun = (state != ST_DONE);
          unique case (state)
          ST_IDLE, ST_TX: begin
            txNext = 1'b1;
            if (stat.priHit)        stateNext = stat.burstHit ? ST_DONE : ST_TX;
            else if (stat.widthHit) stateNext = ST_REST;
            else                    stateNext = ST_TX;
          end
          ST_REST: begin
            if (stat.priHit) stateNext = stat.burstHit ? ST_DONE : ST_TX;
          end
          default: stateNext = ST_DONE;
          endcase
        end
        MODE_CW:    txNext = 1'b1;
        MODE_CHIRP: begin
          cmd.chirpRun = 1'b1;
          txNext       = !stat.chirpHit;
        end
        default:    txNext = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= MODE_PULSED;
      state    <= ST_IDLE;
      txActive <= 1'b0;
    end else begin
      modeQ    <= modeNow;
      state    <= stateNext;
      txActive <= txNext;
    end
  end
endmodule

// File: rtl/tx_gate_top.sv
module tx_gate_top
  import tx_gate_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [1:0]         mode,
  input  logic [CNT_W-1:0]   pulseWidth,
  input  logic [CNT_W-1:0]   priLen,
  input  logic [BURST_W-1:0] pulseCount,
  output logic               txActive
);
  dpCmd_t  cmd;
  dpStat_t stat;

  tx_gate_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .mode     (mode),
    .stat     (stat),
    .cmd      (cmd),
    .txActive (txActive)
  );

  tx_gate_dp #(.CNT_W(CNT_W), .BURST_W(BURST_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .pulseWidth (pulseWidth),
    .priLen     (priLen),
    .pulseCount (pulseCount),
    .stat       (stat)
  );
endmodule

// File: rtl/tx_gate_checker.sv
module tx_gate_checker (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic [1:0] mode,
  input logic       txActive
);
  // R7: a dropped enable closes the gate on the next edge
  assert_enable_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !txActive);

  // R7: a mode change closes the gate on the next edge
  assert_mode_change_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mode != $past(mode)) |=> !txActive);

  // R4: steady continuous tone keeps the gate open
  assert_cw_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && mode == 2'd1 && $stable(mode)) |=> txActive);

  // R5: the chirp dip lasts exactly one cycle
  assert_chirp_dip_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && mode == 2'd2 && $stable(mode) && !txActive) |=> txActive);

  // R8: the off setting keeps the gate closed
  assert_off_mode_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3) |=> !txActive);
endmodule

bind tx_gate_top tx_gate_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .mode     (mode),
  .txActive (txActive)
);

// File: tb/tx_gate_top_tb_top.sv
module tx_gate_top_tb_top;
  localparam int CNT_W   = 16;
  localparam int BURST_W = 8;

  logic               clk = 1'b0;
  logic               rstN;
  logic               enable;
  logic [1:0]         mode;
  logic [CNT_W-1:0]   pulseWidth;
  logic [CNT_W-1:0]   priLen;
  logic [BURST_W-1:0] pulseCount;
  logic               txActive;

  int vectors     = 0;
  int miscompares = 0;
  bit finished    = 0;

  // reference model state
  int mPrev = 0;
  int cPri = 0, kChirp = 0, nPulse = 0;
  bit burstOver = 0;
  bit expTx = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  tx_gate_top #(.CNT_W(CNT_W), .BURST_W(BURST_W)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode),
    .pulseWidth(pulseWidth), .priLen(priLen), .pulseCount(pulseCount),
    .txActive(txActive)
  );

  task automatic check(input bit exp, input string req);
    vectors++;
    if (txActive !== exp) begin
      miscompares++;
      $display("FAIL %s txActive=%0b expected=%0b at %0t", req, txActive, exp, $time);
    end
  endtask

  // one rising edge of the requirements, using current inputs
  function automatic void modelStep();
    int w = int'(pulseWidth);
    int p = int'(priLen);
    int pc = int'(pulseCount);
    bit restart = !enable || (int'(mode) != mPrev);
    mPrev = int'(mode);
    if (restart) begin
      expTx = 0; cPri = 0; kChirp = 0; nPulse = 0; burstOver = 0; tag = "R7";
    end else begin
      case (mode)
        2'd0: begin
          if (burstOver) begin
            expTx = 0; tag = "R3";
          end else begin
            expTx = (cPri < w); tag = (pc != 0) ? "R3" : "R2";
            if (cPri >= p - 1) begin
              cPri = 0; nPulse++;
              if (pc != 0 && nPulse == pc) burstOver = 1;
            end else cPri++;
          end
        end
        2'd1: begin expTx = 1; tag = "R4"; end
        2'd2: begin
          tag = "R5";
          if (kChirp >= w - 1) begin expTx = 0; kChirp = 0; end
          else begin expTx = 1; kChirp++; end
        end
        default: begin expTx = 0; tag = "R8"; end
      endcase
    end
  endfunction

  task automatic step(input bit en, input int md, input int w, input int p, input int pc,
                      input string forceTag);
    enable = en; mode = 2'(md);
    pulseWidth = CNT_W'(w); priLen = CNT_W'(p); pulseCount = BURST_W'(pc);
    modelStep();
    @(negedge clk);
    check(expTx, (forceTag != "") ? forceTag : tag);
  endtask

  // one segment; lengths change only behind one disabled cycle
  task automatic seg(input int md, input int w, input int p, input int pc, input int n,
                     input bit randPri);
    step(0, md, w, p, pc, "R7");
    for (int i = 0; i < n; i++)
      step(1, md, w, randPri ? int'($urandom_range(1, 60)) : p, pc, randPri ? "R6" : "");
  endtask

  initial begin
    void'($urandom(32'd7331));
    rstN = 0; enable = 1; mode = 2'd1;
    pulseWidth = 16'd4; priLen = 16'd9; pulseCount = '0;
    // R1: gate closed while in reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(1'b0, "R1");
    end
    mode = 2'd0;
    @(negedge clk);
    check(1'b0, "R1");
    rstN = 1;
    // R2: basic pulsed pattern, endless
    seg(0, 3, 7, 0, 40, 0);
    // R2 corners: full-width pulse, one-cycle interval
    seg(0, 5, 5, 0, 20, 0);
    seg(0, 1, 1, 0, 8, 0);
    seg(0, 1, 6, 0, 20, 0);
    // R3: bursts of one and three intervals
    seg(0, 2, 5, 1, 20, 0);
    seg(0, 4, 6, 3, 30, 0);
    // R4: continuous tone
    seg(1, 3, 7, 0, 15, 0);
    // R5: shortest chirp and a longer one
    seg(2, 2, 7, 0, 12, 0);
    seg(2, 6, 7, 0, 25, 0);
    // R6: interval length scrambled while chirping
    seg(2, 5, 7, 0, 40, 1);
    // R8: off setting
    seg(3, 3, 7, 0, 6, 0);
    // R7: mode switches without dropping enable
    step(1, 2, 4, 9, 0, "");
    step(1, 2, 4, 9, 0, "");
    step(1, 0, 4, 9, 0, "R7");
    for (int i = 0; i < 12; i++) step(1, 0, 4, 9, 0, "");
    step(1, 1, 4, 9, 0, "R7");
    step(1, 1, 4, 9, 0, "");
    step(1, 2, 4, 9, 0, "R7");
    for (int i = 0; i < 9; i++) step(1, 2, 4, 9, 0, "");
    // random segments
    for (int s = 0; s < 250; s++) begin
      int md = int'($urandom_range(0, 3));
      int w  = int'($urandom_range((md == 2) ? 2 : 1, 20));
      int p  = int'($urandom_range(w, 40));
      int pc = int'($urandom_range(0, 3));
      seg(md, w, p, pc, int'($urandom_range(5, 90)), (md == 2) && ($urandom_range(0, 1) == 1));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule